// File: doc/BRIEF.md
# Interrupt Recognition and Vectoring Unit

This unit sits beside a processor's retirement logic and decides, at every instruction boundary, whether control must be diverted to a service routine and which 8-bit vector selects it. It weighs execution-unit errors, decoder-reported software interrupts and breakpoints, a non-maskable request, the single-step trap flag and a maskable device request. It then emits a one-cycle take strobe with the vector and a flag saying whether the saved return point must re-execute the offending instruction (fault) or continue after it (trap).

A maskable device request is not vectored internally. The unit raises an acknowledge output and holds it until the device signals that its vector is valid on the data bus. It latches that byte in the same cycle and issues the take strobe on the following cycle. No further boundaries are evaluated while this handshake is open. Stack pushes, descriptor lookup and external priority arbitration among devices belong to other blocks.

Top module: `intr_vector_unit`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `take`, `inta`, `restart` are 0 and `vector` is 0x00.
- R2: A boundary (`retire`=1) with `div_err`=1 gives `take`=1 on the next cycle with `vector`=0x00 and `restart`=1 (fault: the instruction restarts).
- R3: At a boundary without a divide error, `ovf_err` gives vector 0x04, else `brk_valid` gives vector 0x03, else `sw_valid` gives `vector`=`sw_num` (any value 0x00..0xFF). All have `restart`=0 (trap).
- R4: A rising edge of `nmi_req` is held pending until taken at a later boundary with vector 0x02 and `restart`=0, whatever `if_flag` holds. A level held high yields exactly one event.
- R5: At a boundary with `tf_flag`=1 and no higher event, vector 0x01 is taken with `restart`=0.
- R6: `intr_req` is recognised at a boundary only when `if_flag`=1; with `if_flag`=0 it produces neither `inta` nor `take`.
- R7: A recognised maskable request raises `inta` on the next cycle and holds it until `ack_valid`=1. On that edge `bus_data` is captured. On the following cycle `take`=1, `vector` equals the captured byte, `restart`=0 and `inta`=0.
- R8: With several events at one boundary the order is divide error, overflow, breakpoint, software interrupt, non-maskable, single-step, maskable. Only the first is taken. A pending non-maskable event survives being outranked, and the other losers are dropped.
- R9: While `inta` is high, `retire` and all event inputs are ignored. When no handshake is open, `ack_valid` is ignored.
- R10: `take` is high for exactly one cycle per event, never without a preceding boundary or acknowledge, and `vector` holds its value between events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire | input | 1 | Instruction boundary strobe |
| div_err | input | 1 | Divide error from execution unit |
| ovf_err | input | 1 | Overflow trap from execution unit |
| brk_valid | input | 1 | One-byte breakpoint opcode decoded |
| sw_valid | input | 1 | Software interrupt instruction decoded |
| sw_num | input | 8 | Vector number carried by the software interrupt |
| tf_flag | input | 1 | Single-step trap flag |
| if_flag | input | 1 | Maskable interrupt enable flag |
| nmi_req | input | 1 | Non-maskable request, edge-sensitive |
| intr_req | input | 1 | Maskable device request, level |
| ack_valid | input | 1 | Device vector valid on data bus |
| bus_data | input | 8 | Data bus carrying device vector |
| inta | output | 1 | Interrupt acknowledge, held during handshake |
| take | output | 1 | One-cycle strobe: divert to vector |
| vector | output | 8 | Selected vector number |
| restart | output | 1 | 1 = fault, return to the faulting instruction |

## Verification
The assertions assume that every input is synchronous to `clk`, that `nmi_req` is already synchronised, and that `bus_data` is valid on the edge where `ack_valid` is sampled high. The stimulus changes inputs only on the falling edge and holds them across the following rising edge. It deliberately asserts `retire`, error flags and `ack_valid` at times the unit must ignore. This shows that such inputs leave the outputs untouched rather than only keeping clear of them.

// File: rtl/ivu_pkg.sv
package ivu_pkg;
  localparam int VEC_W  = 8;
  localparam int NUM_EV = 7;

  // index order is the priority order, 0 highest
  typedef enum logic [2:0] {
    EV_DIV  = 3'd0,
    EV_OVF  = 3'd1,
    EV_BRK  = 3'd2,
    EV_SWI  = 3'd3,
    EV_NMI  = 3'd4,
    EV_STEP = 3'd5,
    EV_EXT  = 3'd6,
    EV_NONE = 3'd7
  } ivu_event_e;

  localparam logic [VEC_W-1:0] VEC_DIV  = VEC_W'(0);
  localparam logic [VEC_W-1:0] VEC_STEP = VEC_W'(1);
  localparam logic [VEC_W-1:0] VEC_NMI  = VEC_W'(2);
  localparam logic [VEC_W-1:0] VEC_BRK  = VEC_W'(3);
  localparam logic [VEC_W-1:0] VEC_OVF  = VEC_W'(4);
endpackage

// File: rtl/ivu_nmi_latch.sv
module ivu_nmi_latch (
  input  logic clk,
  input  logic rst,
  input  logic nmi_req,
  input  logic consume,
  output logic pending
);
  logic nmi_q;
  logic edge_seen;

  assign edge_seen = nmi_req & ~nmi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_q   <= 1'b0;
      pending <= 1'b0;
    end else begin
      nmi_q   <= nmi_req;
      // a fresh edge in the consuming cycle stays pending
      pending <= (pending & ~consume) | edge_seen;
    end
  end
endmodule

// File: rtl/ivu_prio.sv
module ivu_prio
  import ivu_pkg::*;
#(
  parameter int W = VEC_W
) (
  input  logic          evaluate,
  input  logic          div_err,
  input  logic          ovf_err,
  input  logic          brk_valid,
  input  logic          sw_valid,
  input  logic [W-1:0]  sw_num,
  input  logic          nmi_pend,
  input  logic          tf_flag,
  input  logic          intr_ok,
  output ivu_event_e    sel_ev,
  output logic [W-1:0]  sel_vec,
  output logic          sel_fault
);
  logic [NUM_EV-1:0] req;
  logic [W-1:0]      vec_tab [NUM_EV];
  logic [NUM_EV-1:0] fault_tab;

  assign req = {intr_ok, tf_flag, nmi_pend, sw_valid, brk_valid, ovf_err, div_err};

  always_comb begin
    vec_tab[EV_DIV]  = W'(VEC_DIV);
    vec_tab[EV_OVF]  = W'(VEC_OVF);
    vec_tab[EV_BRK]  = W'(VEC_BRK);
    vec_tab[EV_SWI]  = sw_num;
    vec_tab[EV_NMI]  = W'(VEC_NMI);
    vec_tab[EV_STEP] = W'(VEC_STEP);
    vec_tab[EV_EXT]  = '0;
  end

  generate
    for (genvar g = 0; g < NUM_EV; g++) begin : g_fault
      assign fault_tab[g] = (g == int'(EV_DIV));
    end
  endgenerate

  always_comb begin
    sel_ev    = EV_NONE;
    sel_vec   = '0;
    sel_fault = 1'b0;
    if (evaluate) begin
      for (int i = NUM_EV - 1; i >= 0; i--) begin
        if (req[i]) begin
          sel_ev    = ivu_event_e'(i);
          sel_vec   = vec_tab[i];
          sel_fault = fault_tab[i];
        end
      end
    end
  end
endmodule

// File: rtl/ivu_ack_ctl.sv
module ivu_ack_ctl (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic ack_valid,
  output logic busy,
  output logic done
);
  typedef enum logic {S_IDLE, S_WAIT} ack_state_e;
  ack_state_e state;

  assign busy = (state == S_WAIT);
  assign done = busy & ack_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE:  if (start) state <= S_WAIT;
        S_WAIT:  if (ack_valid) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/intr_vector_unit.sv
module intr_vector_unit
  import ivu_pkg::*;
#(
  parameter int W = VEC_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         retire,
  input  logic         div_err,
  input  logic         ovf_err,
  input  logic         brk_valid,
  input  logic         sw_valid,
  input  logic [W-1:0] sw_num,
  input  logic         tf_flag,
  input  logic         if_flag,
  input  logic         nmi_req,
  input  logic         intr_req,
  input  logic         ack_valid,
  input  logic [W-1:0] bus_data,
  output logic         inta,
  output logic         take,
  output logic [W-1:0] vector,
  output logic         restart
);
  logic         busy, done, nmi_pend, evaluate;
  ivu_event_e   sel_ev;
  logic [W-1:0] sel_vec;
  logic         sel_fault;
  logic         start_ack, take_nmi, direct_take;

  assign evaluate    = retire & ~busy;
  assign start_ack   = (sel_ev == EV_EXT);
  assign take_nmi    = (sel_ev == EV_NMI);
  assign direct_take = (sel_ev != EV_NONE) & ~start_ack;

  ivu_nmi_latch u_nmi (
    .clk(clk), .rst(rst), .nmi_req(nmi_req),
    .consume(take_nmi), .pending(nmi_pend)
  );

  ivu_prio #(.W(W)) u_prio (
    .evaluate(evaluate), .div_err(div_err), .ovf_err(ovf_err),
    .brk_valid(brk_valid), .sw_valid(sw_valid), .sw_num(sw_num),
    .nmi_pend(nmi_pend), .tf_flag(tf_flag),
    .intr_ok(intr_req & if_flag),
    .sel_ev(sel_ev), .sel_vec(sel_vec), .sel_fault(sel_fault)
  );

  ivu_ack_ctl u_ack (
    .clk(clk), .rst(rst), .start(start_ack),
    .ack_valid(ack_valid), .busy(busy), .done(done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      take    <= 1'b0;
      inta    <= 1'b0;
      vector  <= '0;
      restart <= 1'b0;
    end else begin
      take <= 1'b0;
      if (done) begin
        inta    <= 1'b0;
        take    <= 1'b1;
        vector  <= bus_data;
        restart <= 1'b0;
      end else if (start_ack) begin
        inta <= 1'b1;
      end else if (direct_take) begin
        take    <= 1'b1;
        vector  <= sel_vec;
        restart <= sel_fault;
      end
    end
  end
endmodule

// File: rtl/ivu_checker.sv
module ivu_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         retire,
  input logic         if_flag,
  input logic         intr_req,
  input logic         ack_valid,
  input logic [W-1:0] bus_data,
  input logic         inta,
  input logic         take,
  input logic [W-1:0] vector,
  input logic         restart
);
  p_fault_vec_r2: assert property (@(posedge clk) disable iff (rst)
    (take && restart) |-> (vector == '0));

  p_mask_gate_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(inta) |-> $past(retire && if_flag && intr_req));

  p_inta_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (inta && !ack_valid) |=> inta);

  p_ack_capture_r7: assert property (@(posedge clk) disable iff (rst)
    (inta && ack_valid) |=> (take && !inta && !restart && vector == $past(bus_data)));

  p_quiet_ack_r9: assert property (@(posedge clk) disable iff (rst)
    inta |-> !take);

  p_take_cause_r10: assert property (@(posedge clk) disable iff (rst)
    take |-> $past(retire || (inta && ack_valid)));

  p_vec_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !take |-> $stable(vector));
endmodule

bind intr_vector_unit ivu_checker #(.W(W)) u_ivu_checker (
  .clk(clk), .rst(rst), .retire(retire), .if_flag(if_flag),
  .intr_req(intr_req), .ack_valid(ack_valid), .bus_data(bus_data),
  .inta(inta), .take(take), .vector(vector), .restart(restart)
);

// File: tb/intr_vector_unit_tb_top.sv
module intr_vector_unit_tb_top;
  logic clk = 1'b0;
  logic rst;
  logic retire, div_err, ovf_err, brk_valid, sw_valid, tf_flag, if_flag;
  logic nmi_req, intr_req, ack_valid;
  logic [7:0] sw_num, bus_data;
  logic inta, take, restart;
  logic [7:0] vector;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  intr_vector_unit dut_i (
    .clk(clk), .rst(rst), .retire(retire), .div_err(div_err),
    .ovf_err(ovf_err), .brk_valid(brk_valid), .sw_valid(sw_valid),
    .sw_num(sw_num), .tf_flag(tf_flag), .if_flag(if_flag),
    .nmi_req(nmi_req), .intr_req(intr_req), .ack_valid(ack_valid),
    .bus_data(bus_data), .inta(inta), .take(take), .vector(vector),
    .restart(restart)
  );

  // behavioural reference
  bit m_ack, m_prev, m_pend;
  bit e_take, e_inta, e_rst;
  int e_vec;
  string m_tag = "R1";

  always @(posedge clk) begin
    bit edge_now, clr;
    int cnt;
    edge_now = nmi_req && !m_prev;
    clr = 0;
    if (rst) begin
      m_ack = 0; m_pend = 0; e_take = 0; e_inta = 0; e_rst = 0; e_vec = 0;
      m_tag = "R1";
      edge_now = 0;
    end else begin
      e_take = 0;
      if (m_ack) begin
        if (ack_valid) begin
          e_take = 1; e_vec = bus_data; e_rst = 0; e_inta = 0; m_ack = 0;
          m_tag = "R7";
        end else m_tag = "R9";
      end else if (retire) begin
        cnt = int'(div_err || ovf_err || brk_valid || sw_valid) + int'(m_pend)
              + int'(tf_flag) + int'(intr_req && if_flag);
        m_tag = "R10";
        if (div_err) begin e_take = 1; e_vec = 0; e_rst = 1; m_tag = "R2"; end
        else if (ovf_err) begin e_take = 1; e_vec = 4; e_rst = 0; m_tag = "R3"; end
        else if (brk_valid) begin e_take = 1; e_vec = 3; e_rst = 0; m_tag = "R3"; end
        else if (sw_valid) begin e_take = 1; e_vec = sw_num; e_rst = 0; m_tag = "R3"; end
        else if (m_pend) begin e_take = 1; e_vec = 2; e_rst = 0; clr = 1; m_tag = "R4"; end
        else if (tf_flag) begin e_take = 1; e_vec = 1; e_rst = 0; m_tag = "R5"; end
        else if (intr_req && if_flag) begin m_ack = 1; e_inta = 1; m_tag = "R7"; end
        else if (intr_req) m_tag = "R6";
        if (cnt > 1) m_tag = "R8";
      end else m_tag = ack_valid ? "R9" : "R10";
      m_pend = (m_pend && !clr) || edge_now;
    end
    m_prev = rst ? 1'b0 : nmi_req;
    cycles++;
  end

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (!finished && cycles > 0) begin
      chk(m_tag, "take", int'(take), int'(e_take));
      chk(rst ? "R1" : "R7", "inta", int'(inta), int'(e_inta));
      chk(m_tag, "vector", int'(vector), e_vec);
      chk(m_tag, "restart", int'(restart), int'(e_rst));
    end
  end

  task automatic clear_pulses();
    retire = 0; div_err = 0; ovf_err = 0; brk_valid = 0; sw_valid = 0;
    ack_valid = 0; sw_num = 8'h00; bus_data = 8'h00;
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic boundary();
    retire = 1; step(); clear_pulses();
  endtask

  initial begin
    rst = 1; clear_pulses(); tf_flag = 0; if_flag = 0; nmi_req = 0; intr_req = 0;
    step(3);
    rst = 0;
    step(2);
    // R2 divide error fault
    div_err = 1; boundary(); step(2);
    // R3 overflow, breakpoint, software numbers at both extremes
    ovf_err = 1; boundary(); step();
    brk_valid = 1; boundary(); step();
    sw_valid = 1; sw_num = 8'hFF; boundary(); step();
    sw_valid = 1; sw_num = 8'h00; boundary(); step();
    // R4 nmi held high, IF clear: one event only
    nmi_req = 1; step(3);
    boundary(); boundary(); boundary(); nmi_req = 0; step(2);
    // R5 single step on consecutive boundaries
    tf_flag = 1; boundary(); boundary(); boundary(); tf_flag = 0; step();
    // R6 masked request ignored
    intr_req = 1; if_flag = 0; boundary(); step(2);
    // R7 + R9 handshake with ignored boundary during it
    if_flag = 1; boundary(); step(2);
    retire = 1; div_err = 1; step(); clear_pulses(); step();
    bus_data = 8'h5A; ack_valid = 1; step(); clear_pulses();
    intr_req = 0; step(2);
    // R9 stray ack when idle
    ack_valid = 1; bus_data = 8'hEE; step(); clear_pulses(); step();
    // R8 everything at once, then nmi remains pending
    nmi_req = 1; step(2); tf_flag = 1; intr_req = 1;
    sw_valid = 1; sw_num = 8'h80; brk_valid = 1; boundary();
    boundary(); boundary(); tf_flag = 0; boundary(); step();
    ack_valid = 1; bus_data = 8'h21; step(); clear_pulses();
    nmi_req = 0; intr_req = 0; step(2);
    // mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      retire    = ($urandom_range(0, 2) == 0);
      div_err   = ($urandom_range(0, 9) == 0);
      ovf_err   = ($urandom_range(0, 9) == 0);
      brk_valid = ($urandom_range(0, 9) == 0);
      sw_valid  = ($urandom_range(0, 9) == 0);
      sw_num    = 8'($urandom);
      tf_flag   = ($urandom_range(0, 5) == 0);
      if_flag   = ($urandom_range(0, 1) == 0);
      if ($urandom_range(0, 7) == 0) nmi_req = ~nmi_req;
      intr_req  = ($urandom_range(0, 3) == 0);
      ack_valid = ($urandom_range(0, 3) == 0);
      bus_data  = 8'($urandom);
      if (i == 2000) rst = 1;
      if (i == 2003) rst = 0;
      step();
    end
    clear_pulses(); intr_req = 0; nmi_req = 0;
    step(3);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule